// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block pairs one 32-bit memory-mapped bus control register with a wait counter for a single external bus port. The register has a 4-bit wait count for each of four external access spaces: X data, Y data, program and I/O. It also holds a page-size code. When a bus cycle begins, the block picks the wait count for that cycle's space and copies it into a private down-counter. It keeps `ready` low until that count has run out.

The page-size code N names a page of 2^N words. The block turns it into a mask with the low N bits set, for a page comparator further along the bus path. A hardware reset (`rst_n`) loads the register with the slowest timing and a 1024-word page. A software reset (`soft_rst`) only aborts a bus cycle that is in progress. It never changes the register.

Top module: `bus_wait_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register is set to 32'h000A_FFFF. Every wait field becomes 15, the page code becomes 4'b1010 (page mask 15'h03FF), and the counter goes idle with `ready` low.
- R2: A write (`reg_wr_en` high at a clock edge) stores `reg_wdata[19:0]`. `reg_rd_data[19:0]` shows the stored bits from the next cycle on. `reg_rd_data[31:20]` always reads zero, whatever was written there.
- R3: `soft_rst` high at a clock edge leaves `reg_rd_data` unchanged. It returns the counter to idle, so an aborted bus cycle produces no `ready` pulse.
- R4: `cyc_space` picks the wait field. 3 = X data uses bits 15:12, 2 = Y data uses bits 11:8, 1 = program uses bits 7:4, and 0 = I/O uses bits 3:0.
- R5: The clock edge that accepts a cycle loads the selected field value W. `ready` is then high in the cycle that follows exactly W further edges after that edge. When W = 0, `ready` is high in the very first cycle after the accepting edge.
- R6: `ready` is a single-cycle pulse at the end of each bus cycle. It is low while the block is idle and while counting.
- R7: A register write made while a bus cycle is counting does not change that cycle's wait count. Only cycles that start later use the new value.
- R8: `cyc_start` is ignored while a cycle is counting with `ready` low. A `cyc_start` in the cycle where `ready` is high starts a new bus cycle right away (back-to-back).
- R9: `page_mask` has exactly its low N bits set, where N is the page code in bits 19:16. N = 0 gives 15'h0000 and N = 15 gives 15'h7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| soft_rst | input | 1 | Software reset; aborts a running bus cycle only |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register contents, reserved bits zero |
| cyc_start | input | 1 | Bus cycle request |
| cyc_space | input | 2 | Access space of the requested cycle |
| ready | output | 1 | Bus cycle completion pulse |
| page_mask | output | 15 | Page offset mask, low N bits set |

## Verification
The bench builds the block with its default parameters: four spaces, 4-bit wait fields and a 4-bit page code. With these values the full wait range from 0 to 15 and every mask width from 0 to 15 bits can be reached in a short run. Each space is given a distinct wait value, so a field taken from the wrong position shows up as a wrong wait length. The page code is driven to both ends of its range. Cycles with `cyc_start` held high show both the back-to-back restart and that requests are ignored while counting. Writes during a cycle and software resets during a cycle are also exercised.

// File: rtl/bwc_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the bus wait-state generator.
// Assumes: nothing beyond standard SystemVerilog.
package bwc_pkg;

    // Wait counter state.
    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_WAIT = 1'b1
    } cnt_state_e;

    // Access space codes; the code doubles as the wait field index.
    typedef enum logic [1:0] {
        SPC_IO   = 2'd0,
        SPC_PROG = 2'd1,
        SPC_YMEM = 2'd2,
        SPC_XMEM = 2'd3
    } bus_space_e;

endpackage

// File: rtl/bwc_ctl_reg.sv
`timescale 1ns/1ps
// Module: bwc_ctl_reg
// Holds the packed wait fields and the page code. Only a hardware reset
// initialises it; it has no software reset input on purpose.
// Assumes: DATA_W >= NUM_SPACES*WAIT_W + PAGE_CODE_W; unused bits read zero.
module bwc_ctl_reg #(
    parameter int DATA_W      = 32,
    parameter int WAIT_W      = 4,
    parameter int NUM_SPACES  = 4,
    parameter int PAGE_CODE_W = 4,
    parameter int PAGE_RST    = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NUM_SPACES*WAIT_W-1:0] wait_fields,
    output logic [PAGE_CODE_W-1:0]       page_code,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int FLD_BITS  = NUM_SPACES * WAIT_W;
    localparam int USED_BITS = FLD_BITS + PAGE_CODE_W;

    logic [FLD_BITS-1:0]    fld_q;
    logic [PAGE_CODE_W-1:0] page_q;
    logic                   unused_hi;

    // Purpose: hardware reset to slowest timing, otherwise accept writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q  <= '1;
            page_q <= PAGE_CODE_W'(PAGE_RST);
        end else if (wr_en) begin
            fld_q  <= wr_data[FLD_BITS-1:0];
            page_q <= wr_data[USED_BITS-1:FLD_BITS];
        end
    end

    // Purpose: form the read image with reserved bits forced to zero.
    always_comb begin
        rd_data                     = '0;
        rd_data[FLD_BITS-1:0]       = fld_q;
        rd_data[USED_BITS-1:FLD_BITS] = page_q;
    end

    assign wait_fields = fld_q;
    assign page_code   = page_q;
    assign unused_hi   = ^wr_data[DATA_W-1:USED_BITS];

endmodule

// File: rtl/bwc_field_sel.sv
`timescale 1ns/1ps
// Module: bwc_field_sel
// Picks the wait field that belongs to the access space of a bus cycle.
// Assumes: field k sits at bits [k*WAIT_W +: WAIT_W]; 2**SPACE_W fields.
module bwc_field_sel #(
    parameter int WAIT_W  = 4,
    parameter int SPACE_W = 2
) (
    input  logic [(2**SPACE_W)*WAIT_W-1:0] fields,
    input  logic [SPACE_W-1:0]             space,
    output logic [WAIT_W-1:0]              sel_wait
);
    localparam int NUM_SPACES = 2 ** SPACE_W;

    logic [WAIT_W-1:0] fld_arr [NUM_SPACES];

    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_unpack
        assign fld_arr[g] = fields[g*WAIT_W +: WAIT_W];
    end

    // Purpose: index the unpacked field array by the space code.
    always_comb begin
        sel_wait = fld_arr[space];
    end

endmodule

// File: rtl/bwc_wait_cnt.sv
`timescale 1ns/1ps
// Module: bwc_wait_cnt
// Down-counter for one bus cycle. It loads its own copy of the wait value
// when a cycle is accepted, so later register writes cannot disturb it.
// Assumes: start is honoured when idle or in the ready cycle; soft_rst aborts.
module bwc_wait_cnt #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              start,
    input  logic [WAIT_W-1:0] load_val,
    output logic              ready,
    output logic              busy
);
    import bwc_pkg::*;

    cnt_state_e        state_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              accept;

    // Purpose: decide completion and whether a new cycle is taken.
    always_comb begin
        ready  = (state_q == CNT_WAIT) && (cnt_q == '0);
        accept = start && ((state_q == CNT_IDLE) || ready);
    end

    // Purpose: load, count down and return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else if (accept) begin
            state_q <= CNT_WAIT;
            cnt_q   <= load_val;
        end else if (ready) begin
            state_q <= CNT_IDLE;
        end else if (state_q == CNT_WAIT) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign busy = (state_q == CNT_WAIT);

endmodule

// File: rtl/bwc_page_dec.sv
`timescale 1ns/1ps
// Module: bwc_page_dec
// Turns a page code N into a mask with the low N bits set.
// Assumes: MASK_W = 2**PAGE_CODE_W - 1, so every code has a mask.
module bwc_page_dec #(
    parameter int PAGE_CODE_W = 4
) (
    input  logic [PAGE_CODE_W-1:0]      page_code,
    output logic [2**PAGE_CODE_W-2:0]   page_mask
);
    localparam int MASK_W = 2 ** PAGE_CODE_W - 1;

    // One thermometer bit per position: set when the code exceeds it.
    for (genvar i = 0; i < MASK_W; i++) begin : g_therm
        assign page_mask[i] = (int'(page_code) > i);
    end

endmodule

// File: rtl/bus_wait_ctl.sv
`timescale 1ns/1ps
// Module: bus_wait_ctl
// Top of the programmable wait-state generator: control register, field
// select, per-cycle wait counter and page mask decoder.
// Assumes: synchronous active-low hardware reset; single register, no address.
module bus_wait_ctl #(
    parameter int DATA_W      = 32,
    parameter int WAIT_W      = 4,
    parameter int SPACE_W     = 2,
    parameter int PAGE_CODE_W = 4,
    parameter int PAGE_RST    = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst,
    input  logic                      reg_wr_en,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rd_data,
    input  logic                      cyc_start,
    input  logic [SPACE_W-1:0]        cyc_space,
    output logic                      ready,
    output logic [2**PAGE_CODE_W-2:0] page_mask
);
    localparam int NUM_SPACES = 2 ** SPACE_W;
    localparam int FLD_BITS   = NUM_SPACES * WAIT_W;

    logic [FLD_BITS-1:0]    wait_fields;
    logic [PAGE_CODE_W-1:0] page_code;
    logic [WAIT_W-1:0]      sel_wait;
    logic                   cnt_busy;

    bwc_ctl_reg #(
        .DATA_W(DATA_W), .WAIT_W(WAIT_W), .NUM_SPACES(NUM_SPACES),
        .PAGE_CODE_W(PAGE_CODE_W), .PAGE_RST(PAGE_RST)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wdata),
        .wait_fields(wait_fields), .page_code(page_code), .rd_data(reg_rd_data)
    );

    bwc_field_sel #(.WAIT_W(WAIT_W), .SPACE_W(SPACE_W)) u_sel (
        .fields(wait_fields), .space(cyc_space), .sel_wait(sel_wait)
    );

    bwc_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(cyc_start),
        .load_val(sel_wait), .ready(ready), .busy(cnt_busy)
    );

    bwc_page_dec #(.PAGE_CODE_W(PAGE_CODE_W)) u_page (
        .page_code(page_code), .page_mask(page_mask)
    );

endmodule

// File: rtl/bwc_checker.sv
`timescale 1ns/1ps
// Module: bwc_checker
// Property checks for bus_wait_ctl, attached by the bind below.
// Assumes: default layout (fields from bit 0, page code right above them).
module bwc_checker #(
    parameter int DATA_W      = 32,
    parameter int WAIT_W      = 4,
    parameter int SPACE_W     = 2,
    parameter int PAGE_CODE_W = 4,
    parameter int PAGE_RST    = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      soft_rst,
    input logic                      reg_wr_en,
    input logic                      cyc_start,
    input logic [SPACE_W-1:0]        cyc_space,
    input logic [DATA_W-1:0]         reg_rd_data,
    input logic                      ready,
    input logic [2**PAGE_CODE_W-2:0] page_mask,
    input logic                      cnt_busy
);
    localparam int FLD_BITS  = (2 ** SPACE_W) * WAIT_W;
    localparam int USED_BITS = FLD_BITS + PAGE_CODE_W;
    localparam int MASK_W    = 2 ** PAGE_CODE_W - 1;

    logic [WAIT_W-1:0]      exp_wait;
    logic [PAGE_CODE_W-1:0] code_rd;
    logic [MASK_W-1:0]      mask_inc;
    logic [DATA_W-1:0]      rst_image;

    // Purpose: decode the read image independently of the design's mux.
    always_comb begin
        exp_wait  = WAIT_W'(reg_rd_data >> (WAIT_W * int'(cyc_space)));
        code_rd   = reg_rd_data[USED_BITS-1:FLD_BITS];
        mask_inc  = page_mask + 1'b1;
        rst_image = '0;
        rst_image[FLD_BITS-1:0]         = '1;
        rst_image[USED_BITS-1:FLD_BITS] = PAGE_CODE_W'(PAGE_RST);
    end

    p_hw_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (reg_rd_data == rst_image) && !ready);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[DATA_W-1:USED_BITS] == '0);

    p_soft_keeps_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && !reg_wr_en |=> $stable(reg_rd_data));

    p_soft_aborts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !ready && !cnt_busy);

    p_zero_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start && !soft_rst && (!cnt_busy || ready) && (exp_wait == '0)
        |=> ready);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_busy |-> !ready);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !cyc_start |=> !ready);

    p_mask_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(page_mask) == int'(code_rd));

    p_mask_contig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (page_mask & mask_inc) == '0);

endmodule

bind bus_wait_ctl bwc_checker #(
    .DATA_W(DATA_W), .WAIT_W(WAIT_W), .SPACE_W(SPACE_W),
    .PAGE_CODE_W(PAGE_CODE_W), .PAGE_RST(PAGE_RST)
) u_bwc_checker (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr_en(reg_wr_en),
    .cyc_start(cyc_start), .cyc_space(cyc_space), .reg_rd_data(reg_rd_data),
    .ready(ready), .page_mask(page_mask), .cnt_busy(cnt_busy)
);

// File: tb/tb_bus_wait_ctl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected wait lengths, the monitor
// measures each bus cycle and compares.
module tb_bus_wait_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rd_data;
    logic        cyc_start = 1'b0;
    logic [1:0]  cyc_space = '0;
    logic        ready;
    logic [14:0] page_mask;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    in_flight = 1'b0;
    bit    direct    = 1'b0;
    int    waited    = 0;

    always #2 clk = ~clk;

    bus_wait_ctl dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data), .cyc_start(cyc_start),
        .cyc_space(cyc_space), .ready(ready), .page_mask(page_mask)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Driver: request one cycle and queue its expected wait count.
    task automatic launch(logic [1:0] sp, int exp_w, string tag);
        @(negedge clk);
        cyc_space = sp;
        cyc_start = 1'b1;
        exp_q.push_back(exp_w);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        cyc_start = 1'b0;
        in_flight = 1'b1;
    endtask

    task automatic finish_cyc();
        wait (!in_flight);
        @(negedge clk);
    endtask

    // Monitor: count waiting cycles, compare on the ready pulse.
    always @(negedge clk) begin
        if (in_flight) begin
            if (ready) begin
                check(tag_q.pop_front(), waited, exp_q.pop_front());
                waited    = 0;
                in_flight = 1'b0;
            end else begin
                waited++;
            end
        end else if (!direct && rst_n && ready) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6: actual ready=1 expected 0 while idle");
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] seen;
        int          pulses;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset image, mask and idle ready
        check("R1 reset image", reg_rd_data, 32'h000A_FFFF);
        check("R1 reset mask", 32'(page_mask), 32'h0000_03FF);
        check("R1 reset ready", 32'(ready), 32'h0);
        rst_n = 1'b1;
        // R1: every space waits 15 after reset
        launch(2'd3, 15, "R1 X wait");  finish_cyc();
        launch(2'd0, 15, "R1 IO wait"); finish_cyc();

        // R2: reserved bits read zero; R9: code 3 -> mask 7
        wr(32'hFFF3_1234);
        check("R2 readback", reg_rd_data, 32'h0003_1234);
        check("R9 mask code 3", 32'(page_mask), 32'h0000_0007);

        // R4/R5: X=1, Y=2, program=3, I/O=4
        launch(2'd3, 1, "R4 X field");    finish_cyc();
        launch(2'd2, 2, "R4 Y field");    finish_cyc();
        launch(2'd1, 3, "R4 prog field"); finish_cyc();
        launch(2'd0, 4, "R4 IO field");   finish_cyc();

        // R9 edges and R5 zero wait
        wr(32'h0000_0F00);
        check("R9 mask code 0", 32'(page_mask), 32'h0000_0000);
        launch(2'd0, 0, "R5 zero wait IO"); finish_cyc();
        launch(2'd3, 0, "R5 zero wait X");  finish_cyc();
        wr(32'h000F_0000);
        check("R9 mask code 15", 32'(page_mask), 32'h0000_7FFF);

        // R7: write during a counting cycle keeps the loaded count
        wr(32'h0005_9000);
        launch(2'd3, 9, "R7 in-flight count");
        repeat (3) @(negedge clk);
        wr(32'h0005_2000);
        finish_cyc();
        launch(2'd3, 2, "R7 later cycle new value"); finish_cyc();

        // R8: start held high, Y field 3 -> pulse every 4 cycles
        direct = 1'b1;
        wr(32'h0000_0300);
        @(negedge clk);
        cyc_space = 2'd2;
        cyc_start = 1'b1;
        seen = '0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            seen[i-1] = ready;
        end
        cyc_start = 1'b0;
        check("R8 back-to-back pattern", 32'(seen), 32'h0000_0888);
        // R6/R8: W=0 held start -> ready every cycle
        wr(32'h0000_0000);
        @(negedge clk);
        cyc_start = 1'b1;
        seen = '0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            seen[i-1] = ready;
        end
        cyc_start = 1'b0;
        check("R8 zero-wait stream", 32'(seen), 32'h0000_000F);
        @(negedge clk);

        // R3: soft reset aborts a cycle and keeps the register
        wr(32'h0007_8888);
        @(negedge clk);
        cyc_space = 2'd1;
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check("R3 register kept", reg_rd_data, 32'h0007_8888);
        pulses = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (ready) pulses++;
        end
        check("R3 aborted cycle no ready", 32'(pulses), 32'h0);
        direct = 1'b0;
        launch(2'd1, 8, "R3 cycle after soft reset"); finish_cyc();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule